// File: doc/BRIEF.md
# LCD Hardware Cursor Overlay

This block places a 64x64 cursor over a live 24-bit RGB pixel stream at a programmable (X,Y) position. Moving the cursor needs only a write of the new coordinate; the frame buffer is never touched. The cursor bitmap sits in an internal dual-port store of 256 words of 32 bits, at 2 bits per cursor pixel. One port serves a simple register/memory write port and the other serves the display path, so software can update the image while pixels flow.

The pixel input carries a valid strobe, a start-of-frame strobe, the current horizontal and vertical counters and the frame pixel. The block reads the cursor store one stage ahead of the output and delays the frame pixel to match. Each input pixel therefore appears at the output, overlaid, with a fixed latency. The bus side holds the cursor enable, the X and Y position, two 24-bit palette colours and the bitmap words.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, pix_valid_o, pix_vsync_o and pix_rgb_o are 0, and every register reads back as 0 (the enable is cleared and both positions are 0).
- R2: pix_valid_o and pix_vsync_o repeat pix_valid_i and pix_vsync_i exactly 2 clock cycles later. Each overlaid pixel leaves with that same 2-cycle latency.
- R3: With the cursor enabled, a pixel is overlaid only when X <= hcnt <= X+63 and Y <= vcnt <= Y+63, using the active position. Every other pixel passes through unchanged.
- R4: Within the window, the cursor code gives the result. Code 0 outputs palette colour 0, code 1 outputs palette colour 1, code 2 passes the frame pixel, and code 3 outputs the bitwise inverse of the frame pixel.
- R5: For window offset (c = hcnt-X, r = vcnt-Y), the code is held in bitmap word r*4 + c/16, in bits [2*(c mod 16)+1 : 2*(c mod 16)].
- R6: A write to the X or Y register does not move the cursor until the next cycle in which pix_vsync_i is high. Pixels of the current frame still use the old position.
- R7: The window is clipped and never wraps. With X or Y near the top of the 12-bit counter range, pixels with small counter values are never overlaid.
- R8: With the enable bit clear, every pixel passes through unchanged, whatever the bitmap and position.
- R9: Bus map, by word address. Bit 8 = 1 selects bitmap word addr[7:0]. Otherwise 0 = control (bit 0 enable), 1 = X[11:0], 2 = Y[11:0], 3 = colour 0 [23:0], 4 = colour 1 [23:0]. A read returns the stored value on bus_rdata_o one cycle after the access. X and Y read back the value written, not the active one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Word address (bit 8 selects bitmap) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after access |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_vsync_i | input | 1 | Start-of-frame strobe |
| pix_hcnt_i | input | 12 | Horizontal counter of input pixel |
| pix_vcnt_i | input | 12 | Vertical counter of input pixel |
| pix_rgb_i | input | 24 | Frame pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_vsync_o | output | 1 | Delayed start-of-frame strobe |
| pix_rgb_o | output | 24 | Overlaid pixel |

## Verification
Overlaid pixels and the delayed strobes are due exactly two cycles after their input, and read data one cycle after a bus read. The bench computes each expected pixel when it drives the input and queues it. A monitor running at the falling edge pops one entry for every output valid, so any change in latency turns into a miscompare. Dedicated probes check that valid and vsync are still low one cycle after the input and high at the second. Position writes are checked against output pixels both before and after the frame strobe.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CNT_W   = 12;
  localparam int PIX_W   = 24;
  localparam int CUR_DIM = 64;
  localparam int RAM_W   = 32;
  localparam int CODE_W  = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_COL0  = 2'b00,
    CODE_COL1  = 2'b01,
    CODE_CLEAR = 2'b10,
    CODE_INV   = 2'b11
  } code_e;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_XPOS = 3'd1,
    REG_YPOS = 3'd2,
    REG_COL0 = 3'd3,
    REG_COL1 = 3'd4
  } reg_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs import cursor_pkg::*; #(
  parameter int CW     = CNT_W,
  parameter int RGB_W  = PIX_W,
  parameter int WORD_W = RAM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        addr_i,
  input  logic [RGB_W-1:0]  wdata_i,
  input  logic              frame_i,
  output logic              en_o,
  output logic [CW-1:0]     x_act_o,
  output logic [CW-1:0]     y_act_o,
  output logic [RGB_W-1:0]  col0_o,
  output logic [RGB_W-1:0]  col1_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [CW-1:0] x_prog, y_prog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      x_prog <= '0;
      y_prog <= '0;
      col0_o <= '0;
      col1_o <= '0;
    end else if (wr_i) begin
      case (reg_e'(addr_i))
        REG_CTRL: en_o   <= wdata_i[0];
        REG_XPOS: x_prog <= wdata_i[CW-1:0];
        REG_YPOS: y_prog <= wdata_i[CW-1:0];
        REG_COL0: col0_o <= wdata_i;
        REG_COL1: col1_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // position is shadowed: only the frame strobe moves the cursor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_act_o <= '0;
      y_act_o <= '0;
    end else if (frame_i) begin
      x_act_o <= x_prog;
      y_act_o <= y_prog;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      case (reg_e'(addr_i))
        REG_CTRL: rdata_o <= WORD_W'(en_o);
        REG_XPOS: rdata_o <= WORD_W'(x_prog);
        REG_YPOS: rdata_o <= WORD_W'(y_prog);
        REG_COL0: rdata_o <= WORD_W'(col0_o);
        REG_COL1: rdata_o <= WORD_W'(col1_o);
        default:  rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cursor_ram.sv
module cursor_ram #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [AW-1:0]     a_addr_i,
  input  logic [WORD_W-1:0] a_wdata_i,
  output logic [WORD_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic [AW-1:0]     b_addr_i,
  output logic [WORD_W-1:0] b_rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_en_i && a_we_i) mem[a_addr_i] <= a_wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (a_en_i && !a_we_i) a_rdata_o <= mem[a_addr_i];
  end

  // display port: old data on a same-cycle write
  always_ff @(posedge clk_i) begin
    if (b_en_i) b_rdata_o <= mem[b_addr_i];
  end
endmodule

// File: rtl/cursor_window.sv
module cursor_window #(
  parameter int CW     = 12,
  parameter int DIM    = 64,
  parameter int PPW    = 16,
  localparam int OFF_W = $clog2(DIM),
  localparam int SUB_W = $clog2(PPW),
  localparam int AW    = OFF_W + OFF_W - SUB_W
) (
  input  logic [CW-1:0]    hcnt_i,
  input  logic [CW-1:0]    vcnt_i,
  input  logic [CW-1:0]    x_i,
  input  logic [CW-1:0]    y_i,
  output logic             hit_o,
  output logic [AW-1:0]    addr_o,
  output logic [SUB_W-1:0] sub_o
);
  logic [CW:0] dx, dy;
  logic        in_x, in_y;

  // one extra bit: a borrow means left of / above the window, never a wrap
  always_comb begin
    dx     = {1'b0, hcnt_i} - {1'b0, x_i};
    dy     = {1'b0, vcnt_i} - {1'b0, y_i};
    in_x   = !dx[CW] && (dx[CW-1:0] < CW'(DIM));
    in_y   = !dy[CW] && (dy[CW-1:0] < CW'(DIM));
    hit_o  = in_x && in_y;
    addr_o = {dy[OFF_W-1:0], dx[OFF_W-1:SUB_W]};
    sub_o  = dx[SUB_W-1:0];
  end
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend import cursor_pkg::*; #(
  parameter int RGB_W  = PIX_W,
  parameter int WORD_W = RAM_W,
  parameter int SUB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              vsync_i,
  input  logic [RGB_W-1:0]  rgb_i,
  input  logic              hit_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [RGB_W-1:0]  col0_i,
  input  logic [RGB_W-1:0]  col1_i,
  output logic              valid_o,
  output logic              vsync_o,
  output logic [RGB_W-1:0]  rgb_o
);
  logic              s1_valid, s1_vsync, s1_hit;
  logic [RGB_W-1:0]  s1_rgb;
  logic [SUB_W-1:0]  s1_sub;
  code_e             code;
  logic [RGB_W-1:0]  mixed;

  // stage 1 runs alongside the bitmap read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_vsync <= 1'b0;
      s1_hit   <= 1'b0;
      s1_rgb   <= '0;
      s1_sub   <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_vsync <= vsync_i;
      s1_hit   <= hit_i;
      s1_rgb   <= rgb_i;
      s1_sub   <= sub_i;
    end
  end

  always_comb begin
    code = code_e'(word_i[s1_sub*CODE_W +: CODE_W]);
    if (!s1_hit) mixed = s1_rgb;
    else begin
      case (code)
        CODE_COL0:  mixed = col0_i;
        CODE_COL1:  mixed = col1_i;
        CODE_CLEAR: mixed = s1_rgb;
        default:    mixed = ~s1_rgb;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vsync_o <= 1'b0;
      rgb_o   <= '0;
    end else begin
      valid_o <= s1_valid;
      vsync_o <= s1_vsync;
      rgb_o   <= mixed;
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import cursor_pkg::*; #(
  parameter int CW      = CNT_W,
  parameter int RGB_W   = PIX_W,
  parameter int DIM     = CUR_DIM,
  parameter int WORD_W  = RAM_W,
  localparam int PPW    = WORD_W / CODE_W,
  localparam int WPR    = DIM / PPW,
  localparam int DEPTH  = DIM * WPR,
  localparam int AW     = $clog2(DEPTH),
  localparam int SUB_W  = $clog2(PPW),
  localparam int BUS_AW = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_write_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              pix_valid_i,
  input  logic              pix_vsync_i,
  input  logic [CW-1:0]     pix_hcnt_i,
  input  logic [CW-1:0]     pix_vcnt_i,
  input  logic [RGB_W-1:0]  pix_rgb_i,
  output logic              pix_valid_o,
  output logic              pix_vsync_o,
  output logic [RGB_W-1:0]  pix_rgb_o
);
  logic              ram_acc, reg_acc, ram_rd_q;
  logic              en_w, hit_w;
  logic [CW-1:0]     x_act_w, y_act_w;
  logic [RGB_W-1:0]  col0_w, col1_w;
  logic [WORD_W-1:0] reg_rdata, ram_rdata, pix_word;
  logic [AW-1:0]     pix_addr;
  logic [SUB_W-1:0]  pix_sub;

  assign ram_acc = bus_sel_i &&  bus_addr_i[AW];
  assign reg_acc = bus_sel_i && !bus_addr_i[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ram_rd_q <= 1'b0;
    else if (bus_sel_i && !bus_write_i)  ram_rd_q <= bus_addr_i[AW];
  end

  assign bus_rdata_o = ram_rd_q ? ram_rdata : reg_rdata;

  cursor_regs #(.CW(CW), .RGB_W(RGB_W), .WORD_W(WORD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_acc && bus_write_i),
    .rd_i    (reg_acc && !bus_write_i),
    .addr_i  (bus_addr_i[2:0]),
    .wdata_i (bus_wdata_i[RGB_W-1:0]),
    .frame_i (pix_vsync_i),
    .en_o    (en_w),
    .x_act_o (x_act_w),
    .y_act_o (y_act_w),
    .col0_o  (col0_w),
    .col1_o  (col1_w),
    .rdata_o (reg_rdata)
  );

  cursor_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
    .clk_i     (clk_i),
    .a_en_i    (ram_acc),
    .a_we_i    (bus_write_i),
    .a_addr_i  (bus_addr_i[AW-1:0]),
    .a_wdata_i (bus_wdata_i),
    .a_rdata_o (ram_rdata),
    .b_en_i    (pix_valid_i),
    .b_addr_i  (pix_addr),
    .b_rdata_o (pix_word)
  );

  cursor_window #(.CW(CW), .DIM(DIM), .PPW(PPW)) u_win (
    .hcnt_i (pix_hcnt_i),
    .vcnt_i (pix_vcnt_i),
    .x_i    (x_act_w),
    .y_i    (y_act_w),
    .hit_o  (hit_w),
    .addr_o (pix_addr),
    .sub_o  (pix_sub)
  );

  cursor_blend #(.RGB_W(RGB_W), .WORD_W(WORD_W), .SUB_W(SUB_W)) u_blend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pix_valid_i),
    .vsync_i (pix_vsync_i),
    .rgb_i   (pix_rgb_i),
    .hit_i   (hit_w && en_w),
    .sub_i   (pix_sub),
    .word_i  (pix_word),
    .col0_i  (col0_w),
    .col1_i  (col1_w),
    .valid_o (pix_valid_o),
    .vsync_o (pix_vsync_o),
    .rgb_o   (pix_rgb_o)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk import cursor_pkg::*; #(
  parameter int CW    = CNT_W,
  parameter int RGB_W = PIX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             pix_vsync_i,
  input logic [CW-1:0]    pix_hcnt_i,
  input logic [RGB_W-1:0] pix_rgb_i,
  input logic             pix_valid_o,
  input logic             pix_vsync_o,
  input logic [RGB_W-1:0] pix_rgb_o,
  input logic             en_w,
  input logic [CW-1:0]    x_act_w
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2))); // R2

  AST_VSYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (pix_vsync_o == $past(pix_vsync_i, 2))); // R2

  AST_DISABLED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && !$past(en_w, 2)) |-> (pix_rgb_o == $past(pix_rgb_i, 2))); // R8

  AST_LEFT_OF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(pix_hcnt_i, 2) < $past(x_act_w, 2))
      |-> (pix_rgb_o == $past(pix_rgb_i, 2))); // R3
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_valid_i (pix_valid_i),
  .pix_vsync_i (pix_vsync_i),
  .pix_hcnt_i  (pix_hcnt_i),
  .pix_rgb_i   (pix_rgb_i),
  .pix_valid_o (pix_valid_o),
  .pix_vsync_o (pix_vsync_o),
  .pix_rgb_o   (pix_rgb_o),
  .en_w        (en_w),
  .x_act_w     (x_act_w)
);

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pv = 1'b0, ps = 1'b0;
  logic [11:0] ph = '0, pvc = '0;
  logic [23:0] prgb = '0;
  logic        valid_o, vsync_o;
  logic [23:0] rgb_o;

  int vectors = 0, miscompares = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  string       tag = "R4";

  logic [31:0] img [256];
  logic        m_en = 1'b0;
  logic [11:0] m_xp = '0, m_yp = '0, m_xa = '0, m_ya = '0;
  logic [23:0] m_c0 = '0, m_c1 = '0;

  always #2 clk = ~clk;

  cursor_overlay u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(bus_sel), .bus_write_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pix_valid_i(pv), .pix_vsync_i(ps), .pix_hcnt_i(ph), .pix_vcnt_i(pvc),
    .pix_rgb_i(prgb),
    .pix_valid_o(valid_o), .pix_vsync_o(vsync_o), .pix_rgb_o(rgb_o)
  );

  function automatic logic [23:0] model(input int h, input int v, input logic [23:0] f);
    int c, r;
    logic [31:0] w;
    logic [1:0]  code;
    if (!m_en) return f;                                   // R8
    if (h < m_xa || h >= m_xa + 64 || v < m_ya || v >= m_ya + 64) return f; // R3 R7
    c = h - m_xa; r = v - m_ya;
    w = img[r*4 + c/16];                                   // R5
    code = w[2*(c%16) +: 2];
    case (code)                                            // R4
      2'b00: return m_c0;
      2'b01: return m_c1;
      2'b10: return f;
      default: return ~f;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: one queued expectation per output valid
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) check("R2 unexpected pixel", 32'(rgb_o), 32'hFFFF_FFFF);
      else check(tag_q.pop_front(), 32'(rgb_o), 32'(exp_q.pop_front()));
    end
  end

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (a[8]) img[a[7:0]] = d;
    else case (a[2:0])
      3'd0: m_en = d[0];
      3'd1: m_xp = d[11:0];
      3'd2: m_yp = d[11:0];
      3'd3: m_c0 = d[23:0];
      3'd4: m_c1 = d[23:0];
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [8:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    check(req, bus_rdata, exp);                            // R9 one cycle later
  endtask

  task automatic pix(input int h, input int v);
    logic [23:0] f;
    f = {h[7:0] ^ 8'h5C, v[7:0], h[11:8], v[11:8]};
    @(negedge clk);
    pv = 1'b1; ps = 1'b0; ph = 12'(h); pvc = 12'(v); prgb = f;
    exp_q.push_back(model(h, v, f));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pv = 1'b0; ps = 1'b0;
    end
  endtask

  task automatic row(input int v, input int h0, input int h1);
    for (int h = h0; h <= h1; h++) pix(h, v);
    idle(3);
  endtask

  task automatic frame_strobe();
    @(negedge clk);
    pv = 1'b0; ps = 1'b1;
    m_xa = m_xp; m_ya = m_yp;
    @(negedge clk);
    ps = 1'b0;
    check("R2 vsync after 1 cycle", 32'(vsync_o), 32'd0);
    @(negedge clk);
    check("R2 vsync after 2 cycles", 32'(vsync_o), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid_o", 32'(valid_o), 32'd0);
    check("R1 vsync_o", 32'(vsync_o), 32'd0);
    check("R1 rgb_o", 32'(rgb_o), 32'd0);
    bus_rd(9'd0, 32'd0, "R1 ctrl");
    bus_rd(9'd1, 32'd0, "R1 xpos");
    bus_rd(9'd2, 32'd0, "R1 ypos");

    // bitmap load and readback (R5, R9)
    for (int i = 0; i < 256; i++)
      bus_wr({1'b1, 8'(i)}, (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_C3C3);
    bus_rd(9'h111, img[17], "R9 bitmap word");
    bus_rd(9'h1FF, img[255], "R9 bitmap last word");
    bus_wr(9'd3, 32'h0011_2233);
    bus_wr(9'd4, 32'h00FF_EE00);
    bus_wr(9'd1, 32'd100);
    bus_wr(9'd2, 32'd50);
    bus_rd(9'd3, 32'h0011_2233, "R9 colour0");
    bus_rd(9'd4, 32'h00FF_EE00, "R9 colour1");
    frame_strobe();

    // R8: disabled, the window rows pass through
    tag = "R8 disabled pass";
    row(60, 95, 170);

    // R2 latency probe
    bus_wr(9'd0, 32'd1);
    bus_rd(9'd0, 32'd1, "R9 ctrl");
    tag = "R2 probe pixel";
    pix(10, 10);
    idle(1);
    check("R2 valid after 1 cycle", 32'(valid_o), 32'd0);
    @(negedge clk);
    check("R2 valid after 2 cycles", 32'(valid_o), 32'd1);
    idle(3);

    // R3 R4 R5: window edges, all codes
    tag = "R4 R5 overlay";
    row(50, 95, 170);
    row(51, 95, 170);
    row(80, 95, 170);
    row(113, 95, 170);
    tag = "R3 outside rows";
    row(49, 95, 170);
    row(114, 95, 170);

    // R6: position write without frame strobe keeps old window
    bus_wr(9'd1, 32'd300);
    bus_rd(9'd1, 32'd300, "R9 xpos programmed");
    tag = "R6 old position";
    row(60, 95, 170);
    row(60, 295, 370);
    frame_strobe();
    tag = "R6 new position";
    row(60, 95, 170);
    row(60, 295, 370);

    // R7: clipping near the counter limit, no wrap
    bus_wr(9'd1, 32'd4070);
    bus_wr(9'd2, 32'd4080);
    frame_strobe();
    tag = "R7 clip edge";
    row(4090, 4060, 4095);
    tag = "R7 no wrap";
    row(4090, 0, 40);
    row(5, 0, 40);
    row(20, 4060, 4095);

    // R8 again after enable cleared
    bus_wr(9'd0, 32'd0);
    tag = "R8 cleared";
    row(4090, 4060, 4095);

    idle(4);
    check("R2 queue drained", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule